// File: doc/BRIEF.md
# Antenna Sample Rate Converter

The block takes one stream of oversampled complex antenna samples and produces three rate-converted versions of it at the same time. The fine-timing output always runs at eight samples per chip. It is built by linear interpolation between adjacent input samples, and two copies of it are delayed by one and by two output samples. The search output runs at two samples per chip and the power output at one sample per chip. Both come from phase-selected decimation, with a half-sample interpolation for the three-samples-per-chip input.

The input oversampling factor is held in a small configuration register. The block clock runs at the 8x output rate, so an input sample arrives every 8/F cycles for an input factor F of 2, 4 or 8. A chip strobe that comes with an input sample marks that sample as phase zero of a chip. Every output carries its own valid strobe. Outside strobe cycles the output keeps its last value.

Top module: `ant_rate_conv`

## Requirements
- R1: A write with `cfg_we_i` high loads `cfg_rate_i` into the rate register, coded 0 = 2x, 1 = 3x, 2 = 4x and 3 = 8x input. With `cfg_we_i` low the rate register is unchanged. After reset the rate is 2x.
- R2: For input factor F in {2,4,8}, let U = 8/F. Each accepted input sample b, with a the sample accepted before it (0 after reset), yields U fine outputs on the U cycles after it. Output k (k = 0..U-1) is round(a + (b-a)·k/U), with halves rounded up, on I and Q separately.
- R3: With a 3x input the fine output never asserts `fine_valid_o`.
- R4: On each fine strobe, `fine_d1_o` equals the previous fine output and `fine_d2_o` equals the one before it (0 after reset).
- R5: The 2x output, one cycle after an accepted sample at chip phase p, keeps the sample when F = 2; when F = 4 and p is even; and when F = 8 and p is a multiple of 4.
- R6: With a 3x input the 2x output emits the sample at phase 0 unchanged. At phase 2 it emits round((x[p1] + x[p2])/2), with halves rounded up. Phase 1 produces nothing.
- R7: The 1x output, one cycle after an accepted sample at chip phase 0, emits that sample, for every input factor.
- R8: An input sample that comes with `chip_i` high has phase 0. Each later sample has the previous phase plus one, wrapping to 0 after F-1. The first sample after reset without a strobe has phase 0.
- R9: Each output changes only on a cycle where its valid strobe is high.
- R10: During reset all valid strobes are low and all sample outputs are zero.
- R11: Samples are packed as {I, Q}, with I in bits 15:8 and Q in bits 7:0, both signed 8-bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock at 8x chip rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Rate register write enable |
| cfg_rate_i | input | 2 | Input rate code |
| in_valid_i | input | 1 | Input sample strobe |
| chip_i | input | 1 | Chip boundary marker for the current input sample |
| in_i | input | 16 | Input sample {I,Q} |
| fine_valid_o | output | 1 | 8x output strobe |
| fine_o | output | 16 | 8x interpolated sample |
| fine_d1_o | output | 16 | 8x sample delayed by one |
| fine_d2_o | output | 16 | 8x sample delayed by two |
| srch_valid_o | output | 1 | 2x output strobe |
| srch_o | output | 16 | 2x sample |
| pwr_valid_o | output | 1 | 1x output strobe |
| pwr_o | output | 16 | 1x sample |

## Verification
The bench runs every input factor and compares each fine, search and power sample against values it works out from the requirements. Signed, odd-valued inputs exercise round-half-up interpolation. A design that truncated would come out one low on negative midpoints. Running the 8x input with back-to-back samples tests a reload on the same cycle as the last emission, which a design that dropped it would lose. A chip strobe in the middle of a chip and an ignored configuration write show up as wrongly picked search samples. The 3x case checks that the fine output stays silent and that the half-sample average uses the previous sample.

// File: rtl/ant_rc_pkg.sv
package ant_rc_pkg;
  localparam int SW = 8;
  localparam int CW = 2 * SW;

  typedef enum logic [1:0] {
    RATE_2X = 2'd0,
    RATE_3X = 2'd1,
    RATE_4X = 2'd2,
    RATE_8X = 2'd3
  } rate_e;

  function automatic logic [3:0] in_factor(rate_e r);
    case (r)
      RATE_2X: return 4'd2;
      RATE_3X: return 4'd3;
      RATE_4X: return 4'd4;
      default: return 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/ant_rc_phase.sv
module ant_rc_phase
  import ant_rc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  rate_e      rate_i,
  input  logic       in_valid_i,
  input  logic       chip_i,
  output logic [2:0] phase_o
);
  logic [2:0] ph_q;
  logic [3:0] fac;

  always_comb begin
    fac = in_factor(rate_i);
    if (chip_i || ({1'b0, ph_q} >= fac - 4'd1)) phase_o = 3'd0;
    else phase_o = ph_q + 3'd1;
  end

  // reset to 7 so an unmarked first sample wraps to phase 0
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) ph_q <= 3'd7;
    else if (in_valid_i) ph_q <= phase_o;

  AST_PHASE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && $stable(rate_i) |=> ({1'b0, ph_q} < fac)); // R8
endmodule

// File: rtl/ant_rc_interp.sv
module ant_rc_interp
  import ant_rc_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  rate_e         rate_i,
  input  logic          in_valid_i,
  input  logic [CW-1:0] in_i,
  output logic          fine_valid_o,
  output logic [CW-1:0] fine_o,
  output logic [CW-1:0] fine_d1_o,
  output logic [CW-1:0] fine_d2_o
);
  localparam int AW = SW + 4;

  logic [2:0]    ratio, k_q;
  logic [1:0]    sh;
  logic [CW-1:0] a_q, b_q;
  logic          busy_q;

  always_comb begin
    case (rate_i)
      RATE_2X: begin ratio = 3'd4; sh = 2'd2; end
      RATE_4X: begin ratio = 3'd2; sh = 2'd1; end
      RATE_8X: begin ratio = 3'd1; sh = 2'd0; end
      default: begin ratio = 3'd0; sh = 2'd0; end
    endcase
  end

  function automatic logic [SW-1:0] mix(logic [SW-1:0] a, logic [SW-1:0] b,
                                        logic [2:0] k, logic [2:0] r, logic [1:0] s);
    logic signed [AW-1:0] wa, wb, wk, wr, acc;
    wa  = AW'($signed(a));
    wb  = AW'($signed(b));
    wk  = $signed({{(AW-3){1'b0}}, k});
    wr  = $signed({{(AW-3){1'b0}}, r});
    acc = wa * (wr - wk) + wb * wk + (wr >>> 1);
    acc = acc >>> s;
    return SW'(acc);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0; b_q <= '0; k_q <= '0; busy_q <= 1'b0;
      fine_valid_o <= 1'b0; fine_o <= '0; fine_d1_o <= '0; fine_d2_o <= '0;
    end else begin
      fine_valid_o <= busy_q && (ratio != 3'd0);
      if (busy_q && ratio != 3'd0) begin
        fine_o    <= {mix(a_q[CW-1:SW], b_q[CW-1:SW], k_q, ratio, sh),
                      mix(a_q[SW-1:0], b_q[SW-1:0], k_q, ratio, sh)};
        fine_d1_o <= fine_o;
        fine_d2_o <= fine_d1_o;
      end
      if (in_valid_i && ratio != 3'd0) begin
        a_q <= b_q; b_q <= in_i; k_q <= '0; busy_q <= 1'b1;
      end else if (busy_q) begin
        k_q <= k_q + 3'd1;
        if (ratio == 3'd0 || k_q == ratio - 3'd1) busy_q <= 1'b0;
      end
    end
  end

  AST_STEP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && ratio != 3'd0 |-> k_q < ratio); // R2
  AST_FINE_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fine_valid_o |->
      (($signed(fine_o[CW-1:SW]) >= $signed($past(a_q[CW-1:SW])) &&
        $signed(fine_o[CW-1:SW]) <= $signed($past(b_q[CW-1:SW]))) ||
       ($signed(fine_o[CW-1:SW]) <= $signed($past(a_q[CW-1:SW])) &&
        $signed(fine_o[CW-1:SW]) >= $signed($past(b_q[CW-1:SW]))))); // R2
  AST_NO_FINE_3X: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rate_i == RATE_3X |=> !fine_valid_o); // R3
endmodule

// File: rtl/ant_rc_decim.sv
module ant_rc_decim
  import ant_rc_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  rate_e         rate_i,
  input  logic          in_valid_i,
  input  logic [2:0]    phase_i,
  input  logic [CW-1:0] in_i,
  output logic          srch_valid_o,
  output logic [CW-1:0] srch_o,
  output logic          pwr_valid_o,
  output logic [CW-1:0] pwr_o
);
  logic [CW-1:0] last_q;
  logic          keep2, half;

  always_comb begin
    case (rate_i)
      RATE_2X: keep2 = 1'b1;
      RATE_4X: keep2 = (phase_i[0] == 1'b0);
      RATE_8X: keep2 = (phase_i[1:0] == 2'd0);
      default: keep2 = (phase_i == 3'd0) || (phase_i == 3'd2);
    endcase
    half = (rate_i == RATE_3X) && (phase_i == 3'd2);
  end

  function automatic logic [SW-1:0] avg(logic [SW-1:0] a, logic [SW-1:0] b);
    logic signed [SW+1:0] s;
    s = (SW+2)'($signed(a)) + (SW+2)'($signed(b)) + (SW+2)'(1);
    s = s >>> 1;
    return SW'(s);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= '0; srch_valid_o <= 1'b0; srch_o <= '0;
      pwr_valid_o <= 1'b0; pwr_o <= '0;
    end else begin
      srch_valid_o <= in_valid_i && keep2;
      pwr_valid_o  <= in_valid_i && (phase_i == 3'd0);
      if (in_valid_i) begin
        last_q <= in_i;
        if (keep2)
          srch_o <= half ? {avg(last_q[CW-1:SW], in_i[CW-1:SW]),
                            avg(last_q[SW-1:0], in_i[SW-1:0])} : in_i;
        if (phase_i == 3'd0) pwr_o <= in_i;
      end
    end
  end

  AST_PWR_EQ_SRCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_valid_o |-> srch_valid_o && (srch_o == pwr_o)); // R7
  AST_SRCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !srch_valid_o && !$past(srch_valid_o) |-> $stable(srch_o)); // R9
endmodule

// File: rtl/ant_rate_conv.sv
module ant_rate_conv
  import ant_rc_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [1:0]    cfg_rate_i,
  input  logic          in_valid_i,
  input  logic          chip_i,
  input  logic [CW-1:0] in_i,
  output logic          fine_valid_o,
  output logic [CW-1:0] fine_o,
  output logic [CW-1:0] fine_d1_o,
  output logic [CW-1:0] fine_d2_o,
  output logic          srch_valid_o,
  output logic [CW-1:0] srch_o,
  output logic          pwr_valid_o,
  output logic [CW-1:0] pwr_o
);
  rate_e      rate_q;
  logic [2:0] phase;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) rate_q <= RATE_2X;
    else if (cfg_we_i) rate_q <= rate_e'(cfg_rate_i);

  ant_rc_phase u_phase (
    .clk_i, .rst_ni, .rate_i(rate_q), .in_valid_i, .chip_i, .phase_o(phase)
  );

  ant_rc_interp u_interp (
    .clk_i, .rst_ni, .rate_i(rate_q), .in_valid_i, .in_i,
    .fine_valid_o, .fine_o, .fine_d1_o, .fine_d2_o
  );

  ant_rc_decim u_decim (
    .clk_i, .rst_ni, .rate_i(rate_q), .in_valid_i, .phase_i(phase), .in_i,
    .srch_valid_o, .srch_o, .pwr_valid_o, .pwr_o
  );

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> $stable(rate_q)); // R1
endmodule

// File: tb/ant_rate_conv_bench.sv
module ant_rate_conv_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_we = 1'b0, in_valid = 1'b0, chip = 1'b0;
  logic [1:0]  cfg_rate = 2'd0;
  logic [15:0] in_d = '0;
  logic        fine_v, srch_v, pwr_v;
  logic [15:0] fine, d1, d2, srch, pwr;

  int errors = 0, checks = 0, hold_err = 0;
  int nf, ns, np;
  int fi[256], fq[256], f1i[256], f1q[256], f2i[256], f2q[256];
  int si[256], sq[256], pi_[256], pq[256];
  int xi[64], xq[64];
  logic [15:0] l_fine, l_d1, l_d2, l_srch, l_pwr;

  always #(CLK_PERIOD/2) clk = ~clk;

  ant_rate_conv u_ant_rate_conv (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_rate_i(cfg_rate),
    .in_valid_i(in_valid), .chip_i(chip), .in_i(in_d),
    .fine_valid_o(fine_v), .fine_o(fine), .fine_d1_o(d1), .fine_d2_o(d2),
    .srch_valid_o(srch_v), .srch_o(srch), .pwr_valid_o(pwr_v), .pwr_o(pwr)
  );

  function automatic int hi8(logic [15:0] v); return int'($signed(v[15:8])); endfunction
  function automatic int lo8(logic [15:0] v); return int'($signed(v[7:0])); endfunction

  always @(negedge clk) if (rst_n) begin
    if (fine_v) begin
      fi[nf] = hi8(fine); fq[nf] = lo8(fine);
      f1i[nf] = hi8(d1); f1q[nf] = lo8(d1); f2i[nf] = hi8(d2); f2q[nf] = lo8(d2);
      if (nf < 255) nf++;
    end else if (fine != l_fine || d1 != l_d1 || d2 != l_d2) hold_err++;
    if (srch_v) begin si[ns] = hi8(srch); sq[ns] = lo8(srch); if (ns < 255) ns++; end
    else if (srch != l_srch) hold_err++;
    if (pwr_v) begin pi_[np] = hi8(pwr); pq[np] = lo8(pwr); if (np < 255) np++; end
    else if (pwr != l_pwr) hold_err++;
    l_fine = fine; l_d1 = d1; l_d2 = d2; l_srch = srch; l_pwr = pwr;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int rnd_div(int num, int den);
    return int'($floor(real'(num) / real'(den) + 0.5));
  endfunction

  // rc: rate code; fac: input factor; mid: index of an extra chip strobe (-1 none)
  task automatic run_case(input int rc, input int fac, input int n, input int gap,
                          input int mid, input string nm);
    int u, ph, pphase, k, ef, es, ep, a, b, pvi, pvq, ppi, ppq, eri, erq;
    bit keep;
    rst_n = 1'b0; in_valid = 1'b0; chip = 1'b0; cfg_we = 1'b0;
    repeat (2) @(negedge clk);
    nf = 0; ns = 0; np = 0; hold_err = 0;
    l_fine = '0; l_d1 = '0; l_d2 = '0; l_srch = '0; l_pwr = '0;
    rst_n = 1'b1;
    cfg_we = 1'b1; cfg_rate = 2'(rc);
    @(negedge clk);
    cfg_we = 1'b0; cfg_rate = 2'((rc + 1) % 4);  // R1: must not load
    repeat (2) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      xi[i] = ((i * 37 + rc * 11) % 255) - 127;
      xq[i] = 101 - ((i * 53 + rc * 7) % 229);
    end
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1; chip = (i % fac == 0) || (i == mid);
      in_d = {8'(xi[i]), 8'(xq[i])};
      @(negedge clk);
      in_valid = 1'b0; chip = 1'b0;
      repeat (gap - 1) @(negedge clk);
    end
    repeat (12) @(negedge clk);
    u = (fac == 3) ? 0 : 8 / fac;
    // fine path R2, R3, R4
    ef = 0; pvi = 0; pvq = 0; ppi = 0; ppq = 0;
    for (int i = 0; i < n && u > 0; i++) begin
      for (k = 0; k < u; k++) begin
        a = (i == 0) ? 0 : xi[i-1]; b = xi[i];
        eri = rnd_div(a * u + (b - a) * k, u);
        a = (i == 0) ? 0 : xq[i-1]; b = xq[i];
        erq = rnd_div(a * u + (b - a) * k, u);
        chk(fi[ef] == eri && fq[ef] == erq, $sformatf("R2 %s fine[%0d] I/Q", nm, ef),
            fi[ef] * 1000 + fq[ef], eri * 1000 + erq);
        chk(f1i[ef] == pvi && f1q[ef] == pvq && f2i[ef] == ppi && f2q[ef] == ppq,
            $sformatf("R4 %s delay[%0d]", nm, ef), f1i[ef] * 1000 + f2i[ef], pvi * 1000 + ppi);
        ppi = pvi; ppq = pvq; pvi = eri; pvq = erq;
        ef++;
      end
    end
    chk(nf == ef, (fac == 3) ? $sformatf("R3 %s fine count", nm)
                             : $sformatf("R2 %s fine count", nm), nf, ef);
    // decimated paths R5..R8
    es = 0; ep = 0; pphase = 7;
    for (int i = 0; i < n; i++) begin
      ph = ((i % fac == 0) || (i == mid) || pphase >= fac - 1) ? 0 : pphase + 1;
      pphase = ph;
      if (fac == 3) keep = (ph == 0) || (ph == 2);
      else keep = (ph % (fac / 2)) == 0;
      if (keep) begin
        if (fac == 3 && ph == 2) begin
          eri = rnd_div(xi[i-1] + xi[i], 2); erq = rnd_div(xq[i-1] + xq[i], 2);
        end else begin eri = xi[i]; erq = xq[i]; end
        chk(si[es] == eri && sq[es] == erq,
            $sformatf("%s %s srch[%0d]", (fac == 3) ? "R6" : (mid >= 0 ? "R8" : "R5"), nm, es),
            si[es] * 1000 + sq[es], eri * 1000 + erq);
        es++;
      end
      if (ph == 0) begin
        chk(pi_[ep] == xi[i] && pq[ep] == xq[i], $sformatf("R7 %s pwr[%0d]", nm, ep),
            pi_[ep] * 1000 + pq[ep], xi[i] * 1000 + xq[i]);
        ep++;
      end
    end
    chk(ns == es, $sformatf("R1 R5 %s srch count", nm), ns, es);
    chk(np == ep, $sformatf("R7 %s pwr count", nm), np, ep);
    chk(hold_err == 0, $sformatf("R9 %s hold between strobes", nm), hold_err, 0);
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(!fine_v && !srch_v && !pwr_v, "R10 valids in reset", {fine_v, srch_v, pwr_v}, 0);
    chk(fine == 0 && d1 == 0 && d2 == 0 && srch == 0 && pwr == 0,
        "R10 outputs in reset", int'(fine | d1 | d2 | srch | pwr), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    test_reset();
    run_case(0, 2, 10, 4, -1, "in2x");   // R11 packing via all cases
    run_case(2, 4, 12, 2, -1, "in4x");
    run_case(3, 8, 20, 1, -1, "in8x");
    run_case(1, 3, 12, 3, -1, "in3x");
    run_case(2, 4, 12, 2, 5,  "midchip");
    run_case(3, 8, 20, 1, 3,  "mid8x");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule